// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative store that sits beside a direct-mapped cache and catches the lines that cache throws out. When the primary cache misses, the controller presents one request. The request carries the missing line address and, if the primary slot held a valid line, the line about to be displaced. Every entry compares its stored line address against the request in the same cycle. On a match, the buffer returns the stored line and takes the displaced primary line into the matching entry in the same operation. The two lines trade places and nothing goes to the next level. On no match, the controller fetches from the next level, and the displaced primary line is parked in the buffer. If this pushes out a modified entry, that entry is handed to lower memory.

The buffer holds lines only from the primary cache, so a line lives either in the cache or in the buffer and never in both. The stored tag is the whole line address, because the buffer has no index. Entries are replaced in least-recently-used order. An entry counts as used when it is written or when it hits.

Top module: `victim_buffer`

## Requirements
- R1: While reset is asserted, and at the first edge after it, `respValid` and `evictValid` are 0 and every entry is empty.
- R2: Each cycle with `reqValid` high produces `respValid` high on the next cycle only. `respValid` is 0 after a cycle without a request.
- R3: `respHitVec` bit i is 1 when entry i (i from 0) holds the requested line address. On a hit exactly one bit is set. On a miss the vector is zero and `respHit` is 0.
- R4: On a hit, `respData` and `respDirty` return the line and modified flag last written into the matching entry.
- R5: On a hit with `reqVictimValid` high, the matching entry is overwritten by the supplied victim line, address and modified flag. The requested line is no longer found in the buffer.
- R6: On a hit with `reqVictimValid` low, the matching entry becomes empty.
- R7: On a miss with `reqVictimValid` high, the victim goes into the lowest-numbered empty entry when one exists, and nothing is evicted.
- R8: When all entries are full, a miss with a victim replaces the entry least recently written or hit.
- R9: A replaced entry appears on `evictValid`/`evictAddr`/`evictData` in the response cycle only if its modified flag is set. A clean replaced entry is dropped silently.
- R10: A miss with `reqVictimValid` low changes no entry, changes no recency order and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Primary-miss request strobe |
| reqAddr | input | ADDR_W | Line address being looked up |
| reqVictimValid | input | 1 | A displaced primary line accompanies the request |
| reqVictimAddr | input | ADDR_W | Line address of the displaced primary line |
| reqVictimData | input | LINE_W | Contents of the displaced primary line |
| reqVictimDirty | input | 1 | Displaced line was modified |
| respValid | output | 1 | Result of the previous cycle's request |
| respHit | output | 1 | Requested line was found |
| respHitVec | output | ENTRIES | One-hot matching entry |
| respData | output | LINE_W | Line returned on a hit |
| respDirty | output | 1 | Modified flag of the returned line |
| evictValid | output | 1 | A modified line leaves toward lower memory |
| evictAddr | output | ADDR_W | Line address of the leaving line |
| evictData | output | LINE_W | Contents of the leaving line |

## Verification
The bench builds the buffer with four entries, 8-bit line addresses and 16-bit lines. It places a two-slot direct-mapped cache model in front of the buffer, with twelve line addresses competing for those two slots. Conflicts are therefore constant. The buffer fills, swaps, frees entries and evicts both clean and dirty lines many times over, and the primary model sometimes drops a line so that requests without a victim occur. A recency-stamp model and a backing-memory model predict each hit vector, returned line and eviction. Every line that round-trips through lower memory is compared against its last written value.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // strobes from the control to the datapath for one request cycle
  typedef struct packed {
    logic doResp;   // capture a lookup result
    logic doWrite;  // write the selected slot
    logic wrValid;  // valid bit written into the slot
    logic doEvict;  // capture the selected slot as an outgoing line
  } vcCtrl_t;
endpackage

// File: rtl/vc_datapath.sv
module vc_datapath #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 256,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [ADDR_W-1:0]   victimAddr,
  input  logic [LINE_W-1:0]   victimData,
  input  logic                victimDirty,
  input  vc_pkg::vcCtrl_t     ctrl,
  input  logic [IDX_W-1:0]    slotIdx,
  output logic [ENTRIES-1:0]  matchVec,
  output logic [ENTRIES-1:0]  validVec,
  output logic [ENTRIES-1:0]  dirtyVec,
  output logic                respValid,
  output logic                respHit,
  output logic [ENTRIES-1:0]  respHitVec,
  output logic [LINE_W-1:0]   respData,
  output logic                respDirty,
  output logic                evictValid,
  output logic [ADDR_W-1:0]   evictAddr,
  output logic [LINE_W-1:0]   evictData
);
  logic [ADDR_W-1:0] tagQ  [ENTRIES];
  logic [LINE_W-1:0] dataQ [ENTRIES];
  logic [ENTRIES-1:0] validQ, dirtyQ;
  logic [LINE_W-1:0] hitData;
  logic hitDirty;

  // one comparator per entry, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g] = validQ[g] && (tagQ[g] == reqAddr);
  end

  assign validVec = validQ;
  assign dirtyVec = dirtyQ;

  // AND-OR read mux driven by the one-hot match
  always_comb begin
    hitData  = '0;
    hitDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitData  = hitData | (dataQ[i] & {LINE_W{matchVec[i]}});
      hitDirty = hitDirty | (dirtyQ[i] & matchVec[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (ctrl.doWrite) begin
      validQ[slotIdx] <= ctrl.wrValid;
      dirtyQ[slotIdx] <= ctrl.wrValid && victimDirty;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.doWrite) begin
      tagQ[slotIdx]  <= victimAddr;
      dataQ[slotIdx] <= victimData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      respHitVec <= '0;
      respData   <= '0;
      respDirty  <= 1'b0;
      evictValid <= 1'b0;
      evictAddr  <= '0;
      evictData  <= '0;
    end else begin
      respValid  <= ctrl.doResp;
      evictValid <= ctrl.doEvict;
      if (ctrl.doResp) begin
        respHit    <= |matchVec;
        respHitVec <= matchVec;
        respData   <= hitData;
        respDirty  <= hitDirty;
      end
      if (ctrl.doEvict) begin
        evictAddr <= tagQ[slotIdx];
        evictData <= dataQ[slotIdx];
      end
    end
  end
endmodule

// File: rtl/vc_control.sv
module vc_control #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                victimValid,
  input  logic [ENTRIES-1:0]  matchVec,
  input  logic [ENTRIES-1:0]  validVec,
  input  logic [ENTRIES-1:0]  dirtyVec,
  output vc_pkg::vcCtrl_t     ctrl,
  output logic [IDX_W-1:0]    slotIdx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // recency rank per entry: 0 = most recent, ENTRIES-1 = least recent
  logic [ENTRIES-1:0][IDX_W-1:0] ageQ;
  logic [IDX_W-1:0] hitIdx, freeIdx, lruIdx;
  logic hit, freeFound, touch;

  always_comb begin
    hitIdx    = '0;
    freeIdx   = '0;
    lruIdx    = '0;
    freeFound = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
      if (ageQ[i] == OLDEST) lruIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx   = IDX_W'(i);
        freeFound = 1'b1;
      end
    end
  end

  assign hit     = reqValid && (|matchVec);
  assign slotIdx = hit ? hitIdx : (freeFound ? freeIdx : lruIdx);
  assign touch   = reqValid && (hit || victimValid);

  always_comb begin
    ctrl         = '0;
    ctrl.doResp  = reqValid;
    ctrl.doWrite = touch;
    ctrl.wrValid = victimValid;
    ctrl.doEvict = reqValid && !hit && victimValid
                   && validVec[slotIdx] && dirtyVec[slotIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == slotIdx) ageQ[i] <= '0;
        else if (ageQ[i] < ageQ[slotIdx]) ageQ[i] <= ageQ[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqVictimValid,
  input  logic [ADDR_W-1:0]   reqVictimAddr,
  input  logic [LINE_W-1:0]   reqVictimData,
  input  logic                reqVictimDirty,
  output logic                respValid,
  output logic                respHit,
  output logic [ENTRIES-1:0]  respHitVec,
  output logic [LINE_W-1:0]   respData,
  output logic                respDirty,
  output logic                evictValid,
  output logic [ADDR_W-1:0]   evictAddr,
  output logic [LINE_W-1:0]   evictData
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vc_pkg::vcCtrl_t    ctrl;
  logic [IDX_W-1:0]   slotIdx;
  logic [ENTRIES-1:0] matchVec, validVec, dirtyVec;

  vc_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .victimValid(reqVictimValid),
    .matchVec(matchVec), .validVec(validVec), .dirtyVec(dirtyVec),
    .ctrl(ctrl), .slotIdx(slotIdx)
  );

  vc_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr),
    .victimAddr(reqVictimAddr), .victimData(reqVictimData),
    .victimDirty(reqVictimDirty), .ctrl(ctrl), .slotIdx(slotIdx),
    .matchVec(matchVec), .validVec(validVec), .dirtyVec(dirtyVec),
    .respValid(respValid), .respHit(respHit), .respHitVec(respHitVec),
    .respData(respData), .respDirty(respDirty), .evictValid(evictValid),
    .evictAddr(evictAddr), .evictData(evictData)
  );
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqVictimValid,
  input logic               respValid,
  input logic               respHit,
  input logic [ENTRIES-1:0] respHitVec
  , input logic             evictValid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!respValid && !evictValid));

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  assert_resp_only_after_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> ($countones(respHitVec) == 1));

  assert_miss_zero_vec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respHitVec == '0));

  assert_evict_on_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> (respValid && !respHit));

  assert_no_victim_no_evict_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqVictimValid) |=> !evictValid);
endmodule

bind victim_buffer vc_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVictimValid(reqVictimValid),
  .respValid(respValid), .respHit(respHit), .respHitVec(respHitVec),
  .evictValid(evictValid)
);

// File: tb/victim_buffer_tb.sv
module victim_buffer_tb;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 8;
  localparam int LINE_W  = 16;
  localparam int NLINES  = 12;
  localparam int NOPS    = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqVictimValid = 1'b0;
  logic [ADDR_W-1:0] reqVictimAddr = '0;
  logic [LINE_W-1:0] reqVictimData = '0;
  logic reqVictimDirty = 1'b0;
  logic respValid, respHit, respDirty, evictValid;
  logic [ENTRIES-1:0] respHitVec;
  logic [LINE_W-1:0] respData, evictData;
  logic [ADDR_W-1:0] evictAddr;

  always #10 clk = ~clk;

  victim_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqVictimValid(reqVictimValid), .reqVictimAddr(reqVictimAddr),
    .reqVictimData(reqVictimData), .reqVictimDirty(reqVictimDirty),
    .respValid(respValid), .respHit(respHit), .respHitVec(respHitVec),
    .respData(respData), .respDirty(respDirty), .evictValid(evictValid),
    .evictAddr(evictAddr), .evictData(evictData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference state
  bit               vbValid [ENTRIES];
  bit               vbDirty [ENTRIES];
  bit               vbSwapped [ENTRIES];
  logic [ADDR_W-1:0] vbAddr [ENTRIES];
  logic [LINE_W-1:0] vbData [ENTRIES];
  int               vbStamp [ENTRIES];
  bit               pValid [2];
  bit               pDirty [2];
  logic [ADDR_W-1:0] pAddr [2];
  logic [LINE_W-1:0] pData [2];
  logic [LINE_W-1:0] mem [NLINES];
  bit               freed [NLINES];
  int               now = 0;
  logic [31:0]      seed = 32'h1234_5678;

  function automatic logic [31:0] nextRnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      vbValid[i] = 0; vbDirty[i] = 0; vbSwapped[i] = 0; vbStamp[i] = -1;
      vbAddr[i] = '0; vbData[i] = '0;
    end
    for (int i = 0; i < 2; i++) begin
      pValid[i] = 0; pDirty[i] = 0; pAddr[i] = '0; pData[i] = '0;
    end
    for (int i = 0; i < NLINES; i++) begin
      mem[i] = LINE_W'(i * 37 + 5);
      freed[i] = 0;
    end

    // R1: quiet outputs during reset
    repeat (3) @(negedge clk);
    chk(!respValid, "R1 respValid in reset", 32'(respValid), 0);
    chk(!evictValid, "R1 evictValid in reset", 32'(evictValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!respValid, "R1 respValid after reset", 32'(respValid), 0);

    for (int op = 0; op < NOPS; op++) begin
      logic [31:0] r;
      int a, pi, s, sel;
      bit expHit, vValid, vDirty;
      logic [ADDR_W-1:0] vAddr;
      logic [LINE_W-1:0] vData;
      r  = nextRnd();
      a  = int'(r[23:16]) % NLINES;
      pi = a % 2;
      if (pValid[pi] && pAddr[pi] == ADDR_W'(a)) begin
        if (r[8]) begin
          pDirty[pi] = 1;
          pData[pi] = pData[pi] ^ r[31:16];
        end
        continue;
      end
      if (r[11:9] == 3'd0 && pValid[pi]) begin
        if (pDirty[pi]) mem[pAddr[pi]] = pData[pi];
        pValid[pi] = 0;
      end
      vValid = pValid[pi]; vDirty = pDirty[pi];
      vAddr = pAddr[pi];   vData = pData[pi];

      expHit = 0; s = 0;
      for (int i = 0; i < ENTRIES; i++)
        if (vbValid[i] && vbAddr[i] == ADDR_W'(a)) begin expHit = 1; s = i; end

      reqValid = 1'b1; reqAddr = ADDR_W'(a);
      reqVictimValid = vValid; reqVictimAddr = vAddr;
      reqVictimData = vData; reqVictimDirty = vDirty;
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0;

      chk(respValid, "R2 respValid after request", 32'(respValid), 1);
      if (expHit) begin
        chk(respHit, vbSwapped[s] ? "R5 hit on swapped line" : "R7 hit on parked line",
            32'(respHit), 1);
        chk(respHitVec == ENTRIES'(1 << s), "R3 hit vector", 32'(respHitVec), 32'(1 << s));
        chk(respData == vbData[s], "R4 hit data", 32'(respData), 32'(vbData[s]));
        chk(respDirty == vbDirty[s], "R4 hit dirty", 32'(respDirty), 32'(vbDirty[s]));
        chk(!evictValid, "R9 no evict on hit", 32'(evictValid), 0);
        pValid[pi] = 1; pAddr[pi] = ADDR_W'(a);
        pData[pi] = vbData[s]; pDirty[pi] = vbDirty[s];
        vbValid[s] = vValid; vbAddr[s] = vAddr; vbData[s] = vData;
        vbDirty[s] = vValid && vDirty; vbSwapped[s] = 1; vbStamp[s] = now++;
        if (!vValid) freed[a] = 1;
      end else begin
        chk(!respHit, freed[a] ? "R6 freed entry misses" : "R3 miss flag",
            32'(respHit), 0);
        chk(respHitVec == '0, "R3 miss vector", 32'(respHitVec), 0);
        if (vValid) begin
          sel = -1;
          for (int i = ENTRIES - 1; i >= 0; i--) if (!vbValid[i]) sel = i;
          if (sel < 0) begin
            sel = 0;
            for (int i = 1; i < ENTRIES; i++) if (vbStamp[i] < vbStamp[sel]) sel = i;
            chk(evictValid == vbDirty[sel], "R9 evict only when dirty",
                32'(evictValid), 32'(vbDirty[sel]));
            if (vbDirty[sel]) begin
              chk(evictAddr == vbAddr[sel], "R8 least recent entry replaced",
                  32'(evictAddr), 32'(vbAddr[sel]));
              chk(evictData == vbData[sel], "R9 evict data",
                  32'(evictData), 32'(vbData[sel]));
              mem[vbAddr[sel]] = vbData[sel];
            end
          end else begin
            chk(!evictValid, "R7 no evict while free entry", 32'(evictValid), 0);
          end
          vbValid[sel] = 1; vbAddr[sel] = vAddr; vbData[sel] = vData;
          vbDirty[sel] = vDirty; vbSwapped[sel] = 0; vbStamp[sel] = now++;
          freed[vAddr] = 0;
        end else begin
          chk(!evictValid, "R10 no evict without victim", 32'(evictValid), 0);
        end
        pValid[pi] = 1; pAddr[pi] = ADDR_W'(a);
        pData[pi] = mem[a]; pDirty[pi] = 0;
      end

      if (r[12]) begin
        @(negedge clk);
        chk(!respValid, "R2 no response without request", 32'(respValid), 0);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule